// File: doc/BRIEF.md
# Grouped Error Interrupt Status Controller

This block gathers eight level-sensitive device interrupt lines and twenty-three error event sources into one 32-bit status word. Error bits latch on a single-cycle event pulse and stay set until software clears them. Software cannot clear one bit at a time. It writes a 7-bit group-reset word, and each set bit of that word clears a fixed group of status bits. A separate multiple-error flag records that a new error arrived while an earlier one was still pending.

An enable mask uses the same bit positions as the status word. The interrupt output is a registered OR of the enabled status bits. Two combinational summaries come straight from the status state. The first flags errors that are fatal. The second flags errors that call for a diagnostic state dump. Software reaches the status word, the mask and the group-reset word through a small register port with a 2-bit address.

Top module: `errgrp_intc`

## Requirements
- R1: After reset the error bits 31:8 of the status word, the enable mask and `irq_o` are all zero.
- R2: Status bits 7:0 show `dev_line_i` level-sensitively and hold no memory; the group-reset word never alters them.
- R3: A pulse on `err_evt_i[i]` sets status bit i+8 at the next clock edge. The bit then holds until its group is cleared.
- R4: A write to address 2 clears groups by data bit: bit 0 clears {8,10,11,12,13,14,15}; bit 1 clears {16,30}; bit 2 clears {17..21}; bit 3 clears {23,24,25,27}; bit 4 clears {9,26,28}; bit 5 clears {22,29}; bit 6 clears {31}. Bits in no selected group are unchanged, and 0x7F clears every error bit.
- R5: When an event and a group clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Bit 31 sets when any event arrives while any of bits 30:8 is already set. Only group-reset bit 6 clears it, and a simultaneous set wins over that clear.
- R7: `irq_o` equals the OR of (status AND enable) as it stood in the previous cycle.
- R8: `fatal_o` is high exactly when any of status bits 13, 14 or 22..29 is set.
- R9: `dump_o` is high exactly when any of status bits 9..16 or 22..30 is set.
- R10: Register map. Address 0 reads the status word, and writes to it are ignored. Address 1 holds the enable mask for reads and writes. Address 2 is write-only and reads zero. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_line_i | input | 8 | Device interrupt lines, level |
| err_evt_i | input | 23 | Error event pulses; bit i maps to status bit i+8 |
| reg_addr_i | input | 2 | Register address |
| reg_wen_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Registered interrupt request |
| fatal_o | output | 1 | Fatal error summary |
| dump_o | output | 1 | Dump-worthy error summary |

## Verification
The assertions assume that the address, write strobe and event inputs are known values at every sampled edge. They also assume that a register write lasts exactly one strobe cycle, so the only way an error bit can fall is a group-reset write. The bench changes every input at the falling clock edge and raises each strobe or event pulse for one cycle only. It never leaves the address undriven. Between sweep steps it returns the status word to a known empty state with a full clear, so the multiple-error flag can only set in the cases that are meant to exercise it.

// File: rtl/errgrp_pkg.sv
package errgrp_pkg;
   localparam int unsigned STAT_BITS = 32;
   localparam int unsigned GRP_BITS  = 7;

   localparam logic [1:0] A_STAT = 2'd0;
   localparam logic [1:0] A_ENA  = 2'd1;
   localparam logic [1:0] A_GRST = 2'd2;

   localparam logic [31:0] GRP_MASK [GRP_BITS] = '{
      (32'h3F << 10) | (32'h1 << 8),
      (32'h1 << 16) | (32'h1 << 30),
      (32'h1F << 17),
      (32'h1 << 23) | (32'h1 << 24) | (32'h1 << 25) | (32'h1 << 27),
      (32'h1 << 9) | (32'h1 << 26) | (32'h1 << 28),
      (32'h1 << 22) | (32'h1 << 29),
      (32'h1 << 31)
   };

   localparam logic [31:0] FATAL_MASK = (32'hFF << 22) | (32'h1 << 13) | (32'h1 << 14);
   localparam logic [31:0] DUMP_MASK  = (32'hFF << 9) | (32'h1FF << 22);

   function automatic logic [31:0] grp_clear_mask(input logic [GRP_BITS-1:0] sel);
      logic [31:0] m;
      m = '0;
      for (int k = 0; k < GRP_BITS; k++) begin
         if (sel[k]) m = m | GRP_MASK[k];
      end
      return m;
   endfunction
endpackage

// File: rtl/errgrp_sticky.sv
module errgrp_sticky #(
   parameter int unsigned ERR_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_W-1:0] evt,
   input  logic [ERR_W-1:0] clr,
   input  logic             multi_clr,
   output logic [ERR_W-1:0] err_q,
   output logic             multi_q
);
   logic multi_set;

   for (genvar i = 0; i < ERR_W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      err_q[i] <= 1'b0;
         else if (evt[i]) err_q[i] <= 1'b1;
         else if (clr[i]) err_q[i] <= 1'b0;
      end
   end

   assign multi_set = (|evt) && (|err_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         multi_q <= 1'b0;
      else if (multi_set) multi_q <= 1'b1;
      else if (multi_clr) multi_q <= 1'b0;
   end
endmodule

// File: rtl/errgrp_summary.sv
module errgrp_summary
   import errgrp_pkg::*;
#(
   parameter int unsigned STAT_W  = 32,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat,
   input  logic [STAT_W-1:0] ena,
   output logic              irq,
   output logic              fatal,
   output logic              dump
);
   logic irq_next;

   assign irq_next = |(stat & ena);
   assign fatal    = |(stat & FATAL_MASK[STAT_W-1:0]);
   assign dump     = |(stat & DUMP_MASK[STAT_W-1:0]);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_next;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_next;
   end
endmodule

// File: rtl/errgrp_intc.sv
module errgrp_intc
   import errgrp_pkg::*;
#(
   parameter int unsigned DEV_LINES = 8,
   parameter int unsigned STAT_W    = 32,
   parameter int unsigned GRP_N     = 7,
   parameter int unsigned ADDR_W    = 2,
   parameter bit          IRQ_REG   = 1'b1,
   localparam int unsigned ERR_W    = STAT_W - DEV_LINES - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEV_LINES-1:0] dev_line_i,
   input  logic [ERR_W-1:0]  err_evt_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wen_i,
   input  logic [STAT_W-1:0] reg_wdata_i,
   output logic [STAT_W-1:0] reg_rdata_o,
   output logic              irq_o,
   output logic              fatal_o,
   output logic              dump_o
);
   if (DEV_LINES != 8 || STAT_W != STAT_BITS || GRP_N != GRP_BITS || ADDR_W < 2) begin : g_bad_cfg
      $error("errgrp_intc: unsupported geometry");
   end

   logic [STAT_W-1:0] enable_q;
   logic [STAT_W-1:0] clr_mask;
   logic [STAT_W-1:0] stat_vec;
   logic [ERR_W-1:0]  err_q;
   logic              multi_q;
   logic              ena_wr;
   logic              grp_wr;

   assign ena_wr   = reg_wen_i && (reg_addr_i == ADDR_W'(A_ENA));
   assign grp_wr   = reg_wen_i && (reg_addr_i == ADDR_W'(A_GRST));
   assign clr_mask = grp_wr ? grp_clear_mask(reg_wdata_i[GRP_N-1:0]) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      enable_q <= '0;
      else if (ena_wr) enable_q <= reg_wdata_i;
   end

   errgrp_sticky #(.ERR_W(ERR_W)) u_sticky (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (err_evt_i),
      .clr       (clr_mask[STAT_W-2:DEV_LINES]),
      .multi_clr (clr_mask[STAT_W-1]),
      .err_q     (err_q),
      .multi_q   (multi_q)
   );

   assign stat_vec = {multi_q, err_q, dev_line_i};

   errgrp_summary #(.STAT_W(STAT_W), .IRQ_REG(IRQ_REG)) u_summary (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (stat_vec),
      .ena   (enable_q),
      .irq   (irq_o),
      .fatal (fatal_o),
      .dump  (dump_o)
   );

   always_comb begin
      reg_rdata_o = '0;
      if (reg_addr_i == ADDR_W'(A_STAT))     reg_rdata_o = stat_vec;
      else if (reg_addr_i == ADDR_W'(A_ENA)) reg_rdata_o = enable_q;
   end
endmodule

// File: rtl/errgrp_intc_chk.sv
module errgrp_intc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [22:0] evt,
   input logic        wen,
   input logic [1:0]  addr,
   input logic [31:0] stat,
   input logic [31:0] ena,
   input logic        irq,
   input logic        fatal,
   input logic        dump
);
   // R3/R4: error bits only fall on a group-reset write
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wen && addr == 2'd2) |=> (($past(stat[31:8]) & ~stat[31:8]) == 24'h0));

   // R3/R5: every pulsed event is visible in the status word one edge later
   p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != 23'h0) |=> ((stat[30:8] & $past(evt)) == $past(evt)));

   // R6: the multi-error flag only rises after an event on a non-empty error set
   p_multi_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[31]) |-> ($past(evt) != 23'h0) && ($past(stat[30:8]) != 23'h0));

   // R7: interrupt is the enabled status seen one cycle earlier
   p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(stat & ena))));

   // R8/R9: every fatal source is also a dump source
   p_fatal_in_dump_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |-> dump);
endmodule

bind errgrp_intc errgrp_intc_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .evt   (err_evt_i),
   .wen   (reg_wen_i),
   .addr  (reg_addr_i),
   .stat  (stat_vec),
   .ena   (enable_q),
   .irq   (irq_o),
   .fatal (fatal_o),
   .dump  (dump_o)
);

// File: tb/errgrp_intc_bench.sv
`timescale 1ns/1ps
module errgrp_intc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  dev_line = '0;
   logic [22:0] err_evt = '0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wen = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, fatal, dump;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   errgrp_intc u_errgrp_intc (
      .clk(clk), .rst_n(rst_n), .dev_line_i(dev_line), .err_evt_i(err_evt),
      .reg_addr_i(reg_addr), .reg_wen_i(reg_wen), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .irq_o(irq), .fatal_o(fatal), .dump_o(dump));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input int b);
      @(negedge clk);
      err_evt = 23'(1) << (b - 8);
      @(negedge clk);
      err_evt = '0;
   endtask

   function automatic int grp_of(input int b);
      if (b == 8 || (b >= 10 && b <= 15)) return 0;
      if (b == 16 || b == 30)             return 1;
      if (b >= 17 && b <= 21)             return 2;
      if (b == 23 || b == 24 || b == 25 || b == 27) return 3;
      if (b == 9 || b == 26 || b == 28)   return 4;
      if (b == 22 || b == 29)             return 5;
      return 6;
   endfunction

   initial begin
      #(5.0 * 100000);
      n_err++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 status", v, 32'h0);
      rd(2'd1, v); chk("R1 enable", v, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R10 map
      wr(2'd1, 32'h1234_5678);
      rd(2'd1, v); chk("R10 enable rw", v, 32'h1234_5678);
      rd(2'd2, v); chk("R10 grst reads zero", v, 32'h0);
      rd(2'd3, v); chk("R10 addr3 reads zero", v, 32'h0);
      wr(2'd1, 32'h0);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); chk("R10 status write ignored", v, 32'h0);

      // R2 device lines
      dev_line = 8'hA5;
      rd(2'd0, v); chk("R2 dev level", v, 32'h0000_00A5);
      wr(2'd2, 32'h7F);
      rd(2'd0, v); chk("R2 grst no effect", v, 32'h0000_00A5);
      wr(2'd1, 32'h1);
      @(negedge clk);
      chk("R7 irq from dev", {31'h0, irq}, 32'h1);
      dev_line = 8'h00;
      rd(2'd0, v); chk("R2 not sticky", v, 32'h0);
      @(negedge clk);
      chk("R7 irq drops", {31'h0, irq}, 32'h0);
      wr(2'd1, 32'h0);

      // sweep every error bit against every group
      for (int b = 8; b <= 30; b++) begin
         wr(2'd2, 32'h7F);
         pulse(b);
         rd(2'd0, v); chk($sformatf("R3 set bit %0d", b), v, 32'h1 << b);
         chk($sformatf("R8 fatal bit %0d", b), {31'h0, fatal},
             {31'h0, (b == 13 || b == 14 || (b >= 22 && b <= 29))});
         chk($sformatf("R9 dump bit %0d", b), {31'h0, dump},
             {31'h0, ((b >= 9 && b <= 16) || (b >= 22 && b <= 30))});
         wr(2'd1, 32'h1 << b);
         @(negedge clk);
         chk($sformatf("R7 irq bit %0d", b), {31'h0, irq}, 32'h1);
         wr(2'd1, 32'h0);
         for (int g = 0; g < 7; g++) begin
            wr(2'd2, 32'h1 << g);
            rd(2'd0, v);
            chk($sformatf("R4 bit %0d grp %0d", b, g), v,
                (grp_of(b) == g) ? 32'h0 : (32'h1 << b));
            if (grp_of(b) == g) pulse(b);
         end
      end

      // R4 all-clear
      wr(2'd2, 32'h7F);
      rd(2'd0, v); chk("R4 full clear", v, 32'h0);

      // R5 event beats clear
      pulse(10);
      @(negedge clk);
      err_evt = 23'(1) << (12 - 8);
      reg_addr = 2'd2; reg_wdata = 32'h1; reg_wen = 1'b1;
      @(negedge clk);
      err_evt = '0; reg_wen = 1'b0;
      rd(2'd0, v); chk("R5 event wins", v, (32'h1 << 12) | (32'h1 << 31));

      // R6 multi-error
      wr(2'd2, 32'h7F);
      pulse(9);
      rd(2'd0, v); chk("R6 single no multi", v, 32'h1 << 9);
      pulse(17);
      rd(2'd0, v); chk("R6 multi set", v, (32'h1 << 9) | (32'h1 << 17) | (32'h1 << 31));
      wr(2'd2, 32'h40);
      rd(2'd0, v); chk("R6 multi cleared alone", v, (32'h1 << 9) | (32'h1 << 17));
      @(negedge clk);
      err_evt = 23'(1) << (20 - 8);
      reg_addr = 2'd2; reg_wdata = 32'h40; reg_wen = 1'b1;
      @(negedge clk);
      err_evt = '0; reg_wen = 1'b0;
      rd(2'd0, v); chk("R6 set wins", v[31:0] & 32'h8000_0000, 32'h8000_0000);
      wr(2'd2, 32'h7F);
      rd(2'd0, v); chk("R4 final clear", v, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule